// File: doc/BRIEF.md
# Fractional master clock divider

This block turns a fast source clock into an audio master clock whose period averages a non-integer number of source cycles, N + b/a. Most periods last N source cycles. A phase accumulator decides which periods are stretched by one cycle, so that b periods out of every a are N+1 cycles long. A second counter divides the master clock by an integer to give the bit clock. It also raises a one-cycle marker at the start of each bit-clock group.

The integer part, the fraction numerator and denominator, and the bit-clock divider are static inputs. Software chooses them for a target rate and changes them only while the block is disabled. A design that needs separate transmit and receive timing places one instance per direction, each with its own settings. All three outputs are registered in the source clock domain. While the enable is low, every output is held low and the whole phase state is cleared.

Top module: `frac_mclk_div`

## Requirements
- R1: While rst_ni is low or en_i is low, mclk_o, bck_o and bck_en_o are 0. At the first rising edge that samples en_i high, mclk_o goes to 1 and master period 0 begins.
- R2: The effective integer part is max(int_div_i, 2). An int_div_i of 0 or 1 behaves exactly like 2.
- R3: The fraction is active only when 2 <= frac_den_i and 1 <= frac_num_i < frac_den_i. With any other pair, for example den 1 with num 0, or num equal to den, every master period lasts exactly the effective integer part.
- R4: Counting master periods from 0 after enable, period 0 is never stretched. Period k >= 1 is one source cycle longer than the integer part when floor(k*b/a) - floor((k-1)*b/a) = 1, where a is the denominator and b the numerator.
- R5: With the fraction active, periods 1 to a contain exactly b stretched periods, and so does every later window of a consecutive periods.
- R6: Within each master period of L source cycles, mclk_o is 1 for the first floor(L/2) cycles and 0 for the rest.
- R7: The effective bit divider is D = max(bck_div_i, 2). bck_en_o is 1 for exactly the first source cycle of each master period k with k mod D = 0, and 0 in all other cycles.
- R8: bck_o is 1 during master periods with k mod D < floor(D/2) and 0 otherwise. It changes only on the first cycle of a master period.
- R9: Dropping en_i in the middle of a period forces all three outputs to 0 at the next edge. Re-enabling restarts at period 0 with the accumulator cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable; low clears the state and holds the outputs low |
| int_div_i | input | N_W (8) | Integer part N of the master divide ratio |
| frac_den_i | input | A_W (6) | Fraction denominator a |
| frac_num_i | input | A_W (6) | Fraction numerator b |
| bck_div_i | input | D_W (8) | Master-to-bit clock divider |
| mclk_o | output | 1 | Master clock |
| bck_en_o | output | 1 | One-cycle marker at the start of each bit-clock group |
| bck_o | output | 1 | Bit clock |

## Verification
The difficult cycle is one where a stretched master period coincides with the start of a bit-clock group. The longer period must not shift the group marker or the bit-clock edge away from the master rising edge. The bench sweeps every numerator for denominators up to 6 against several bit dividers, so stretched periods land on group boundaries many times. At each master rising edge it checks the period length against the floor-difference formula, and the marker and bit-clock level against the period index modulo the bit divider. A second collision, the enable falling in mid-period while a stretch is pending, is forced by a direct disable. The bench then checks that the outputs clear at once and that the next run starts from period 0.

// File: rtl/frac_mclk_pkg.sv
package frac_mclk_pkg;
  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} run_st_e;
  localparam int unsigned MIN_INT_DIV = 2;
  localparam int unsigned MIN_BCK_DIV = 2;
endpackage

// File: rtl/mclk_frac_acc.sv
module mclk_frac_acc #(
  parameter int unsigned A_W = 6
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           clear_i,
  input  logic           step_i,
  input  logic [A_W-1:0] den_i,
  input  logic [A_W-1:0] num_i,
  output logic           stretch_q_o,
  output logic           stretch_d_o
);
  logic [A_W-1:0] acc_q, acc_d;
  logic [A_W:0]   sum;
  logic           str_q, str_d;
  logic           frac_on;

  assign frac_on = (den_i > A_W'(1)) && (num_i != '0) && (num_i < den_i);

  always_comb begin
    sum   = {1'b0, acc_q} + {1'b0, num_i};
    acc_d = acc_q;
    str_d = str_q;
    if (clear_i) begin
      acc_d = '0;
      str_d = 1'b0;
    end else if (step_i) begin
      if (!frac_on) begin
        acc_d = '0;
        str_d = 1'b0;
      end else if (sum >= {1'b0, den_i}) begin
        acc_d = A_W'(sum - {1'b0, den_i});
        str_d = 1'b1;
      end else begin
        acc_d = sum[A_W-1:0];
        str_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q <= '0;
      str_q <= 1'b0;
    end else begin
      acc_q <= acc_d;
      str_q <= str_d;
    end
  end

  assign stretch_q_o = str_q;
  assign stretch_d_o = str_d;

  AST_ACC_BELOW_DEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frac_on |-> acc_q < den_i); // R5
  AST_CLEAR_NO_STRETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> !str_q); // R9
endmodule

// File: rtl/mclk_period_gen.sv
module mclk_period_gen
  import frac_mclk_pkg::*;
#(
  parameter int unsigned N_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [N_W-1:0] n_i,
  input  logic           stretch_q_i,
  input  logic           stretch_d_i,
  output logic           step_o,
  output logic           first_o,
  output logic           mclk_o
);
  localparam int unsigned C_W = N_W + 1;

  run_st_e        st_q, st_d;
  logic [C_W-1:0] cnt_q, cnt_d;
  logic [C_W-1:0] n_eff, len_q, len_d;
  logic           last;
  logic           mclk_q, mclk_d;

  assign n_eff   = (n_i < N_W'(MIN_INT_DIV)) ? C_W'(MIN_INT_DIV) : {1'b0, n_i};
  assign len_q   = n_eff + C_W'(stretch_q_i);
  assign len_d   = n_eff + C_W'(stretch_d_i);
  assign last    = cnt_q >= (len_q - C_W'(1));
  assign first_o = en_i && (st_q == ST_IDLE);
  assign step_o  = en_i && (st_q == ST_RUN) && last;

  always_comb begin
    if (!en_i) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      mclk_d = 1'b0;
    end else begin
      st_d   = ST_RUN;
      cnt_d  = (first_o || last) ? '0 : cnt_q + C_W'(1);
      // high phase is the first floor(len/2) cycles
      mclk_d = cnt_d < (len_d >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      mclk_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      mclk_q <= mclk_d;
    end
  end

  assign mclk_o = mclk_q;

  AST_MCLK_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !mclk_o); // R1
  AST_CNT_IN_PERIOD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) |-> cnt_q < len_q); // R4
  AST_MCLK_HIGH_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) && (cnt_q == '0) |-> mclk_q); // R6
  AST_MCLK_LOW_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_RUN) && (cnt_q == len_q - C_W'(1)) |-> !mclk_q); // R6
endmodule

// File: rtl/bck_div_gen.sv
module bck_div_gen
  import frac_mclk_pkg::*;
#(
  parameter int unsigned D_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           first_i,
  input  logic           start_i,
  input  logic [D_W-1:0] div_i,
  output logic           bck_o,
  output logic           bck_en_o
);
  logic [D_W-1:0] d_eff;
  logic [D_W-1:0] grp_q, grp_d;
  logic           bck_q, bck_d;
  logic           ben_q, ben_d;

  assign d_eff = (div_i < D_W'(MIN_BCK_DIV)) ? D_W'(MIN_BCK_DIV) : div_i;

  always_comb begin
    grp_d = grp_q;
    bck_d = bck_q;
    ben_d = 1'b0;
    if (!en_i) begin
      grp_d = '0;
      bck_d = 1'b0;
    end else if (start_i) begin
      if (first_i || grp_q >= d_eff - D_W'(1)) grp_d = '0;
      else                                     grp_d = grp_q + D_W'(1);
      ben_d = (grp_d == '0);
      bck_d = grp_d < (d_eff >> 1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grp_q <= '0;
      bck_q <= 1'b0;
      ben_q <= 1'b0;
    end else begin
      grp_q <= grp_d;
      bck_q <= bck_d;
      ben_q <= ben_d;
    end
  end

  assign bck_o    = bck_q;
  assign bck_en_o = ben_q;

  AST_BCK_EN_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ben_q |=> !ben_q); // R7
  AST_BCK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i && !start_i |=> $stable(bck_q)); // R8
  AST_BCK_EN_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ben_q |-> bck_q); // R8
endmodule

// File: rtl/frac_mclk_div.sv
module frac_mclk_div #(
  parameter int unsigned N_W = 8,
  parameter int unsigned A_W = 6,
  parameter int unsigned D_W = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [N_W-1:0] int_div_i,
  input  logic [A_W-1:0] frac_den_i,
  input  logic [A_W-1:0] frac_num_i,
  input  logic [D_W-1:0] bck_div_i,
  output logic           mclk_o,
  output logic           bck_en_o,
  output logic           bck_o
);
  logic step, first, str_q, str_d, acc_clr, per_start;

  assign acc_clr   = !en_i || first;
  assign per_start = step || first;

  mclk_frac_acc #(.A_W(A_W)) u_acc (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clear_i    (acc_clr),
    .step_i     (step),
    .den_i      (frac_den_i),
    .num_i      (frac_num_i),
    .stretch_q_o(str_q),
    .stretch_d_o(str_d)
  );

  mclk_period_gen #(.N_W(N_W)) u_per (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .en_i       (en_i),
    .n_i        (int_div_i),
    .stretch_q_i(str_q),
    .stretch_d_i(str_d),
    .step_o     (step),
    .first_o    (first),
    .mclk_o     (mclk_o)
  );

  bck_div_gen #(.D_W(D_W)) u_bck (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .first_i (first),
    .start_i (per_start),
    .div_i   (bck_div_i),
    .bck_o   (bck_o),
    .bck_en_o(bck_en_o)
  );

  AST_BCK_EN_ON_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bck_en_o |-> mclk_o && !$past(mclk_o)); // R7
  AST_OFF_ALL_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> !bck_o && !bck_en_o); // R9
endmodule

// File: tb/sim_frac_mclk_div.sv
module sim_frac_mclk_div;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic [7:0] n_div = '0;
  logic [5:0] den = '0;
  logic [5:0] num = '0;
  logic [7:0] bdiv = '0;
  logic       mclk, bck_en, bck;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  frac_mclk_div u0 (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .int_div_i(n_div),
    .frac_den_i(den), .frac_num_i(num), .bck_div_i(bdiv),
    .mclk_o(mclk), .bck_en_o(bck_en), .bck_o(bck)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic all_low(input string tag);
    chk(mclk == 1'b0, tag, int'(mclk), 0);
    chk(bck == 1'b0, tag, int'(bck), 0);
    chk(bck_en == 1'b0, tag, int'(bck_en), 0);
  endtask

  task automatic run_cfg(input int n, input int a, input int b, input int d, input int np);
    int ne, de, s, cyc, hi, extra_en, bvar, win;
    bit fon;
    logic prev, bck0;
    string tag;
    @(negedge clk);
    en = 1'b0; n_div = 8'(n); den = 6'(a); num = 6'(b); bdiv = 8'(d);
    @(negedge clk);
    all_low("R1 idle");
    en = 1'b1;
    @(negedge clk);
    chk(mclk == 1'b1, "R1 start", int'(mclk), 1);
    ne  = (n < 2) ? 2 : n;
    de  = (d < 2) ? 2 : d;
    fon = (a >= 2) && (b >= 1) && (b < a);
    tag = (n < 2) ? "R2" : (fon ? "R4" : "R3");
    win = 0;
    for (int k = 0; k < np; k++) begin
      s = (k == 0 || !fon) ? 0 : (k * b) / a - ((k - 1) * b) / a;
      chk(bck_en == ((k % de) == 0), "R7 marker", int'(bck_en), int'((k % de) == 0));
      chk(bck == ((k % de) < (de / 2)), "R8 level", int'(bck), int'((k % de) < (de / 2)));
      bck0 = bck; cyc = 0; hi = 0; extra_en = 0; bvar = 0;
      do begin
        cyc++;
        if (mclk) hi++;
        if (cyc > 1 && bck_en) extra_en++;
        if (bck !== bck0) bvar++;
        prev = mclk;
        @(negedge clk);
      end while (!(mclk && !prev) && cyc < 1000);
      chk(cyc == ne + s, tag, cyc, ne + s);
      chk(hi == (ne + s) / 2, "R6", hi, (ne + s) / 2);
      chk(extra_en == 0, "R7 extra", extra_en, 0);
      chk(bvar == 0, "R8 hold", bvar, 0);
      if (k >= 1 && k <= a) win += cyc - ne;
    end
    if (np > a) chk(win == (fon ? b : 0), "R5", win, fon ? b : 0);
  endtask

  initial begin
    int dl[6];
    int ni[5];
    dl = '{0, 1, 2, 3, 4, 8};
    ni = '{0, 1, 2, 3, 6};
    repeat (2) @(negedge clk);
    all_low("R1 reset");
    rst_n = 1'b1;
    @(negedge clk);
    all_low("R1 after reset");

    for (int i = 0; i < 5; i++)
      for (int a = 1; a <= 6; a++)
        for (int b = 0; b <= a; b++)
          run_cfg(ni[i], a, b, dl[(i + a + b) % 6], 2 * a + 2 * ((dl[(i + a + b) % 6] < 2) ? 2 : dl[(i + a + b) % 6]) + 2);

    // R9: mid-period disable with accumulator non-zero, then restart
    @(negedge clk);
    en = 1'b0; n_div = 8'd5; den = 6'd3; num = 6'd2; bdiv = 8'd4;
    @(negedge clk);
    en = 1'b1;
    repeat (13) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    all_low("R9 drop");
    run_cfg(5, 3, 2, 4, 10);
    @(negedge clk);
    en = 1'b1;
    repeat (6) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    all_low("R9 drop high");
    run_cfg(3, 5, 4, 3, 14);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule